// File: doc/BRIEF.md
# Cross-Domain Trigger Event Capture

This block collects single-cycle event pulses raised in a slow endpoint clock domain and hands them to a reader in a faster host clock domain. Each bit of a trigger vector is sticky in the endpoint domain, so a pulse lasting one endpoint cycle is kept however long the host waits before it looks.

When the host asks for an update, a request level flips in the host domain and is synchronized into the endpoint domain. There the pending bits move into a hold register and leave the accumulator in the same edge. The endpoint then flips an acknowledge level back toward the host. Only when that acknowledge has crossed does the host register the held value and raise a one-cycle completion strobe. Nothing on the host side depends on a fixed latency, so the result is correct for any ratio between the two clock periods, including an endpoint clock about five times slower than the host clock.

A per-bit query port reports whether a selected trigger bit is set in the most recent completed snapshot.

Top module: `trig_capture_xdom`

## Requirements
- R1: A one-cycle high pulse on any bit of `ep_trig_i`, sampled on a rising `eclk_i` edge, is reported as 1 in that bit position of `snap_o` after the next completed update.
- R2: A pending bit stays pending until an update captures it. Several pulses on the same bit before one update are reported as a single 1, and pulses on different bits before one update are reported together as their bitwise OR.
- R3: A request on `upd_req_i` (high for one `hclk_i` cycle) ends with `upd_done_o` high for exactly one `hclk_i` cycle. `snap_o` takes its new value on the same edge that raises `upd_done_o` and changes at no other time.
- R4: Bits that an update has captured are cleared from the endpoint accumulator. A following update with no new pulses reports all zeros.
- R5: A pulse that arrives in the same endpoint cycle as a capture is kept in the accumulator and is reported by the following update, so no event is lost.
- R6: A request made while an earlier request is still outstanding (after the request, before its `upd_done_o`) is ignored: it produces no extra `upd_done_o` and no extra capture.
- R7: `query_hit_o` equals bit `query_idx_i` of `snap_o` (bit 0 is the least significant bit of the trigger vector) and follows `query_idx_i` without a clock.
- R8: While `hrst_i` and `erst_i` are high, `snap_o`, `upd_done_o` and `query_hit_o` are 0. Pulses seen before the reset are discarded and are not reported by the first update after it.
- R9: Captures are correct when the endpoint clock period is about five times the host clock period: a pulse seen one endpoint cycle before the request is still reported by that request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| hclk_i | input | 1 | Host interface clock |
| hrst_i | input | 1 | Active-high synchronous reset, host domain |
| eclk_i | input | 1 | Endpoint clock |
| erst_i | input | 1 | Active-high synchronous reset, endpoint domain |
| ep_trig_i | input | TRIG_W | Trigger pulses, synchronous to `eclk_i` |
| upd_req_i | input | 1 | Host request to capture pending triggers |
| upd_done_o | output | 1 | One-cycle strobe: new snapshot is valid |
| snap_o | output | TRIG_W | Most recently completed snapshot |
| query_idx_i | input | IDX_W | Bit index to query |
| query_hit_o | output | 1 | Selected snapshot bit |

## Verification
The bench goes after a pulse that lands next to a capture. A design that cleared the whole accumulator on capture would lose it, and one that kept captured bits would report a stale event twice on the next empty update. It holds the request high and re-requests mid-flight: a design without the outstanding-request guard would flip the request twice and either issue a second completion or cancel the first toggle and never finish. The slow endpoint clock checks that the host does not take the hold register before the acknowledge arrives. A host that read on a fixed delay would return zeros for pulses it should report. Reset in the middle of a run checks that pending bits from before the reset do not leak into the first snapshot after it.

// File: rtl/trig_xdom_pkg.sv
package trig_xdom_pkg;

   // Width of an index that selects one of n bits (at least 1).
   function automatic int unsigned idx_width(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

   // Host-side handshake state.
   typedef enum logic {
      HS_IDLE = 1'b0,
      HS_WAIT = 1'b1
   } hs_state_e;

endpackage

// File: rtl/tx_sync_chain.sv
// Multi-stage level synchronizer, reset to zero.
module tx_sync_chain #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic d_i,
   output logic q_o
);

   logic [STAGES-1:0] sr_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tx_sync_chain: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         sr_q <= '0;
      end else begin
         sr_q <= {sr_q[STAGES-2:0], d_i};
      end
   end

   assign q_o = sr_q[STAGES-1];

endmodule

// File: rtl/tx_ep_side.sv
// Endpoint domain: sticky accumulator, request detect, hold register, ack toggle.
module tx_ep_side #(
   parameter int unsigned TRIG_W      = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              eclk_i,
   input  logic              erst_i,
   input  logic [TRIG_W-1:0] trig_i,
   input  logic              req_tgl_i,
   output logic [TRIG_W-1:0] hold_o,
   output logic              ack_tgl_o,
   output logic [TRIG_W-1:0] acc_o,
   output logic              cap_o
);

   logic              req_sync;
   logic              req_last_q;
   logic              cap;
   logic [TRIG_W-1:0] acc_q;
   logic [TRIG_W-1:0] hold_q;
   logic              ack_q;

   tx_sync_chain #(.STAGES(SYNC_STAGES)) u_req_sync (
      .clk_i (eclk_i),
      .rst_i (erst_i),
      .d_i   (req_tgl_i),
      .q_o   (req_sync)
   );

   // One extra stage so the last two can be compared for a new request.
   always_ff @(posedge eclk_i) begin
      if (erst_i) begin
         req_last_q <= 1'b0;
      end else begin
         req_last_q <= req_sync;
      end
   end

   assign cap = req_sync ^ req_last_q;

   // Per-bit sticky accumulator. On a capture, the bit restarts from
   // the pulse of this very cycle so a coincident event survives.
   generate
      for (genvar gi = 0; gi < TRIG_W; gi++) begin : g_acc
         always_ff @(posedge eclk_i) begin
            if (erst_i) begin
               acc_q[gi] <= 1'b0;
            end else if (cap) begin
               acc_q[gi] <= trig_i[gi];
            end else if (trig_i[gi]) begin
               acc_q[gi] <= 1'b1;
            end
         end
      end
   endgenerate

   always_ff @(posedge eclk_i) begin
      if (erst_i) begin
         hold_q <= '0;
         ack_q  <= 1'b0;
      end else if (cap) begin
         hold_q <= acc_q;
         ack_q  <= ~ack_q;
      end
   end

   assign hold_o    = hold_q;
   assign ack_tgl_o = ack_q;
   assign acc_o     = acc_q;
   assign cap_o     = cap;

endmodule

// File: rtl/tx_host_side.sv
// Host domain: request toggle, outstanding guard, ack detect, snapshot, query.
module tx_host_side
   import trig_xdom_pkg::*;
#(
   parameter int unsigned TRIG_W      = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned IDX_W       = 4
) (
   input  logic              hclk_i,
   input  logic              hrst_i,
   input  logic              upd_req_i,
   input  logic [TRIG_W-1:0] hold_i,
   input  logic              ack_tgl_i,
   input  logic [IDX_W-1:0]  query_idx_i,
   output logic              req_tgl_o,
   output logic              busy_o,
   output logic [TRIG_W-1:0] snap_o,
   output logic              done_o,
   output logic              hit_o
);

   localparam int unsigned IDX_SPAN = 1 << IDX_W;

   hs_state_e         state_q;
   logic              req_q;
   logic              ack_sync;
   logic              ack_last_q;
   logic              ack_edge;
   logic [TRIG_W-1:0] snap_q;
   logic              done_q;

   tx_sync_chain #(.STAGES(SYNC_STAGES)) u_ack_sync (
      .clk_i (hclk_i),
      .rst_i (hrst_i),
      .d_i   (ack_tgl_i),
      .q_o   (ack_sync)
   );

   always_ff @(posedge hclk_i) begin
      if (hrst_i) begin
         ack_last_q <= 1'b0;
      end else begin
         ack_last_q <= ack_sync;
      end
   end

   assign ack_edge = ack_sync ^ ack_last_q;

   always_ff @(posedge hclk_i) begin
      if (hrst_i) begin
         state_q <= HS_IDLE;
         req_q   <= 1'b0;
         snap_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            HS_IDLE: begin
               if (upd_req_i) begin
                  req_q   <= ~req_q;
                  state_q <= HS_WAIT;
               end
            end
            HS_WAIT: begin
               if (ack_edge) begin
                  snap_q  <= hold_i;
                  done_q  <= 1'b1;
                  state_q <= HS_IDLE;
               end
            end
            default: state_q <= HS_IDLE;
         endcase
      end
   end

   // Query mux: unguarded when the index range matches the width exactly.
   generate
      if (IDX_SPAN == TRIG_W) begin : g_query_exact
         assign hit_o = snap_q[query_idx_i];
      end else begin : g_query_guarded
         always_comb begin
            hit_o = 1'b0;
            for (int unsigned i = 0; i < TRIG_W; i++) begin
               if (query_idx_i == IDX_W'(i)) begin
                  hit_o = snap_q[i];
               end
            end
         end
      end
   endgenerate

   assign req_tgl_o = req_q;
   assign busy_o    = (state_q == HS_WAIT);
   assign snap_o    = snap_q;
   assign done_o    = done_q;

endmodule

// File: rtl/trig_capture_xdom.sv
module trig_capture_xdom
   import trig_xdom_pkg::*;
#(
   parameter int unsigned TRIG_W      = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned IDX_W       = idx_width(TRIG_W)
) (
   input  logic              hclk_i,
   input  logic              hrst_i,
   input  logic              eclk_i,
   input  logic              erst_i,
   input  logic [TRIG_W-1:0] ep_trig_i,
   input  logic              upd_req_i,
   output logic              upd_done_o,
   output logic [TRIG_W-1:0] snap_o,
   input  logic [IDX_W-1:0]  query_idx_i,
   output logic              query_hit_o
);

   generate
      if (TRIG_W < 1) begin : g_bad_width
         $error("trig_capture_xdom: TRIG_W must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("trig_capture_xdom: SYNC_STAGES must be at least 2");
      end
      if ((1 << IDX_W) < TRIG_W) begin : g_bad_idx
         $error("trig_capture_xdom: IDX_W too narrow for TRIG_W");
      end
   endgenerate

   logic              h_req_tgl;
   logic              h_busy;
   logic              e_ack_tgl;
   logic [TRIG_W-1:0] e_hold;
   logic [TRIG_W-1:0] e_acc;
   logic              e_cap;

   tx_ep_side #(
      .TRIG_W      (TRIG_W),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_ep (
      .eclk_i    (eclk_i),
      .erst_i    (erst_i),
      .trig_i    (ep_trig_i),
      .req_tgl_i (h_req_tgl),
      .hold_o    (e_hold),
      .ack_tgl_o (e_ack_tgl),
      .acc_o     (e_acc),
      .cap_o     (e_cap)
   );

   tx_host_side #(
      .TRIG_W      (TRIG_W),
      .SYNC_STAGES (SYNC_STAGES),
      .IDX_W       (IDX_W)
   ) u_host (
      .hclk_i      (hclk_i),
      .hrst_i      (hrst_i),
      .upd_req_i   (upd_req_i),
      .hold_i      (e_hold),
      .ack_tgl_i   (e_ack_tgl),
      .query_idx_i (query_idx_i),
      .req_tgl_o   (h_req_tgl),
      .busy_o      (h_busy),
      .snap_o      (snap_o),
      .done_o      (upd_done_o),
      .hit_o       (query_hit_o)
   );

endmodule

// File: rtl/trig_capture_xdom_chk.sv
module trig_capture_xdom_chk #(
   parameter int unsigned TRIG_W = 16
) (
   input logic              hclk_i,
   input logic              hrst_i,
   input logic              eclk_i,
   input logic              erst_i,
   input logic [TRIG_W-1:0] ep_trig_i,
   input logic              upd_req_i,
   input logic              upd_done_o,
   input logic [TRIG_W-1:0] snap_o,
   input logic [TRIG_W-1:0] acc,
   input logic [TRIG_W-1:0] hold,
   input logic              cap,
   input logic              busy,
   input logic              req_tgl
);

   // R1: a sampled pulse is pending in the accumulator one edge later.
   p_trig_latched_r1: assert property (@(posedge eclk_i) disable iff (erst_i)
      1'b1 |=> ((acc & $past(ep_trig_i)) == $past(ep_trig_i)));

   // R2: without a capture, pending bits are never dropped.
   p_acc_sticky_r2: assert property (@(posedge eclk_i) disable iff (erst_i)
      !cap |=> ((acc & $past(acc)) == $past(acc)));

   // R5: after a capture only the pulses of the capture cycle remain.
   p_cap_keeps_new_r5: assert property (@(posedge eclk_i) disable iff (erst_i)
      cap |=> (acc == $past(ep_trig_i)));

   // R4: the hold register moves only on a capture.
   p_hold_on_cap_r4: assert property (@(posedge eclk_i) disable iff (erst_i)
      !cap |=> $stable(hold));

   // R3: completion strobe lasts one host cycle.
   p_done_one_cycle_r3: assert property (@(posedge hclk_i) disable iff (hrst_i)
      upd_done_o |=> !upd_done_o);

   // R3: snapshot changes only together with the completion strobe.
   p_snap_with_done_r3: assert property (@(posedge hclk_i) disable iff (hrst_i)
      !upd_done_o |-> $stable(snap_o));

   // R6: a request during an outstanding update does not flip the request.
   p_busy_ignores_r6: assert property (@(posedge hclk_i) disable iff (hrst_i)
      (busy && upd_req_i) |=> $stable(req_tgl));

endmodule

bind trig_capture_xdom trig_capture_xdom_chk #(.TRIG_W(TRIG_W)) u_chk (
   .hclk_i     (hclk_i),
   .hrst_i     (hrst_i),
   .eclk_i     (eclk_i),
   .erst_i     (erst_i),
   .ep_trig_i  (ep_trig_i),
   .upd_req_i  (upd_req_i),
   .upd_done_o (upd_done_o),
   .snap_o     (snap_o),
   .acc        (e_acc),
   .hold       (e_hold),
   .cap        (e_cap),
   .busy       (h_busy),
   .req_tgl    (h_req_tgl)
);

// File: tb/trig_capture_xdom_tb_top.sv
`timescale 1ns/1ps
module trig_capture_xdom_tb_top;

   localparam int unsigned TW    = 16;
   localparam int unsigned IW    = 4;
   localparam real         HHALF = 5.0;   // 100 MHz host clock
   localparam real         EHALF = 24.0;  // endpoint period 4.8x the host period
   localparam int unsigned NVEC  = 6;

   // Each vector: {first pulse mask, second pulse mask, expected snapshot}
   localparam logic [47:0] VEC [NVEC] = '{
      {16'h0001, 16'h0000, 16'h0001},
      {16'h8000, 16'h0000, 16'h8000},
      {16'hA5A5, 16'h5A5A, 16'hFFFF},
      {16'h0F00, 16'h0F00, 16'h0F00},
      {16'h0000, 16'h0000, 16'h0000},
      {16'h1234, 16'h0041, 16'h1275}
   };

   logic          hclk = 1'b0;
   logic          eclk = 1'b0;
   logic          hrst = 1'b1;
   logic          erst = 1'b1;
   logic [TW-1:0] trig = '0;
   logic          req  = 1'b0;
   logic [IW-1:0] qidx = '0;
   logic          done;
   logic [TW-1:0] snap;
   logic          hit;

   int n_chk  = 0;
   int n_fail = 0;

   always #(HHALF) hclk = ~hclk;
   always #(EHALF) eclk = ~eclk;

   trig_capture_xdom #(.TRIG_W(TW)) dut_i (
      .hclk_i      (hclk),
      .hrst_i      (hrst),
      .eclk_i      (eclk),
      .erst_i      (erst),
      .ep_trig_i   (trig),
      .upd_req_i   (req),
      .upd_done_o  (done),
      .snap_o      (snap),
      .query_idx_i (qidx),
      .query_hit_o (hit)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic pulse(input logic [TW-1:0] m);
      @(negedge eclk) trig = m;
      @(negedge eclk) trig = '0;
   endtask

   // Issue one request and wait for completion; returns snapshot and whether done came.
   task automatic update(output logic [TW-1:0] s, output logic seen);
      seen = 1'b0;
      s    = '0;
      @(negedge hclk) req = 1'b1;
      @(negedge hclk) req = 1'b0;
      for (int i = 0; i < 400; i++) begin
         if (done) begin
            seen = 1'b1;
            s    = snap;
            break;
         end
         @(negedge hclk);
      end
   endtask

   task automatic update_check(input string tag, input logic [TW-1:0] exp);
      logic [TW-1:0] s;
      logic          seen;
      update(s, seen);
      check({tag, " done seen"}, 32'(seen), 32'd1);
      check({tag, " snapshot"}, 32'(s), 32'(exp));
      @(negedge hclk);
      check("R3 done single cycle", 32'(done), 32'd0);
   endtask

   initial begin
      #(500_000);
      n_fail++;
      $display("FAIL watchdog R1..R9 actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int dcount;
      // R8: reset state
      repeat (4) @(negedge eclk);
      check("R8 snap in reset", 32'(snap), 32'd0);
      check("R8 done in reset", 32'(done), 32'd0);
      check("R8 hit in reset", 32'(hit), 32'd0);
      @(negedge eclk) begin hrst = 1'b0; erst = 1'b0; end
      repeat (2) @(negedge eclk);

      // R1, R2, R3: vector table
      for (int v = 0; v < NVEC; v++) begin
         pulse(VEC[v][47:32]);
         pulse(VEC[v][31:16]);
         update_check($sformatf("R1 R2 R3 vec%0d", v), VEC[v][15:0]);
      end

      // R4: captured bits cleared
      pulse(16'h00F0);
      update_check("R4 first", 16'h00F0);
      update_check("R4 empty after capture", 16'h0000);

      // R7: query against a known snapshot
      pulse(16'hA5A5);
      update_check("R7 load", 16'hA5A5);
      for (int b = 0; b < TW; b++) begin
         qidx = IW'(b);
         #1;
         check($sformatf("R7 query bit %0d", b), 32'(hit), 32'((16'hA5A5 >> b) & 1));
      end

      // R9: pulse one endpoint cycle before the request (slow endpoint clock)
      @(negedge eclk) trig = 16'h4000;
      @(negedge eclk) trig = '0;
      update_check("R9 late pulse", 16'h4000);

      // R5: a bit pulsed every endpoint cycle across captures is never lost
      @(negedge eclk) trig = 16'h0008;
      update_check("R5 stream 1", 16'h0008);
      update_check("R5 stream 2", 16'h0008);
      @(negedge eclk) trig = '0;
      update_check("R5 tail kept", 16'h0008);
      update_check("R5 drained", 16'h0000);

      // R6: request held and re-issued while outstanding
      pulse(16'h0100);
      dcount = 0;
      @(negedge hclk) req = 1'b1;
      repeat (2) @(negedge hclk);
      req = 1'b0;
      repeat (2) @(negedge hclk);
      req = 1'b1;
      @(negedge hclk) req = 1'b0;
      for (int i = 0; i < 300; i++) begin
         if (done) begin
            dcount++;
            check("R6 snapshot", 32'(snap), 32'h0100);
         end
         @(negedge hclk);
      end
      check("R6 one completion", 32'(dcount), 32'd1);
      pulse(16'h0002);
      update_check("R6 next update clean", 16'h0002);

      // R8: reset mid-run discards pending bits
      pulse(16'h0C00);
      @(negedge eclk) begin hrst = 1'b1; erst = 1'b1; end
      repeat (3) @(negedge eclk);
      check("R8 snap after reset", 32'(snap), 32'd0);
      @(negedge eclk) begin hrst = 1'b0; erst = 1'b0; end
      repeat (2) @(negedge eclk);
      update_check("R8 pending discarded", 16'h0000);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule